// File: doc/BRIEF.md
# Local Bus Ownership Arbiter with CPU Parking

This block decides which of four masters owns the shared local bus and the DRAM behind it. The processor is the parked owner. It holds the bus whenever nobody else is asking for it. The other three masters each raise a request, receive a grant, run their work and give the bus back:

- a peripheral DMA engine, which is held to a single cycle per grant;
- a network controller, which keeps its grant for as long as it holds its request;
- a slave port facing the VMEbus, which asks for the bus only while its address decode points at onboard DRAM.

The DRAM timing logic sits outside the block. It reports back through a cycle-done strobe, a read flag and a parity-error flag. The block uses these to end the DMA tenure, to return a bus error to the DMA engine on a bad read, and to answer the VMEbus master with DTACK or BERR.

Ownership changes only at cycle boundaries. There is always one idle clock with no grant between two owners. The block is wired between the requesting masters and the local bus multiplexer.

Top module: `lb_arbiter`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the next state has `gnt_cpu` high, the other three grants low, and `vme_dtack`, `vme_berr` and `dma_berr` low.
- R2: Parking. With no DMA request, no network request and no qualified VME request, the processor keeps its grant. After an idle clock in which no request is seen, the grant returns to the processor on the next clock.
- R3: The processor loses its grant only at a clock edge where `cpu_busy` is sampled low and at least one other request is pending. While `cpu_busy` is high, the grant stays with the processor.
- R4: Any change of owner passes through exactly one clock in which all four grants are low. Two different grants are never high on adjacent clocks.
- R5: In the idle clock the winner is chosen by fixed priority, highest first: qualified VME request, then network, then DMA. With none of these present, the processor wins.
- R6: The DMA engine gives up the bus at the first edge where `cyc_done` is sampled high during its grant, even if `dma_req` stays high.
- R7: `dma_berr` is combinational. It is high exactly when `gnt_dma`, `cyc_done`, `cyc_rd` and `cyc_err` are all high.
- R8: A VME request counts only when `vme_sel` and `vme_strobe` are both high. Either one alone causes no grant.
- R9: The VME port behaves as follows:
  - It keeps its grant until the DRAM cycle ends.
  - On the clock after `cyc_done`, it raises `vme_berr` if `parity_en` and `cyc_err` were high with `cyc_done`. Otherwise it raises `vme_dtack`.
  - The raised response and `gnt_vme` stay high until `vme_strobe` is sampled low. After that edge the block enters the idle clock.
- R10: The network controller keeps its grant while `net_req` stays high. It loses it at the first edge where `net_req` is sampled low.
- R11: At most one grant is high in any clock. `vme_dtack` and `vme_berr` are never high together, and neither is high without `gnt_vme`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_busy | input | 1 | Processor is in the middle of a local bus cycle |
| dma_req | input | 1 | DMA engine asks for the bus |
| net_req | input | 1 | Network controller asks for the bus |
| vme_sel | input | 1 | VME address decode hits onboard DRAM |
| vme_strobe | input | 1 | VME data strobe is asserted |
| cyc_done | input | 1 | Current DRAM cycle completes this clock |
| cyc_rd | input | 1 | Current DRAM cycle is a read |
| cyc_err | input | 1 | Parity error on the current DRAM cycle, valid with `cyc_done` |
| parity_en | input | 1 | Parity reporting to the VME port is enabled |
| gnt_cpu | output | 1 | Processor owns the bus |
| gnt_dma | output | 1 | DMA engine owns the bus |
| gnt_net | output | 1 | Network controller owns the bus |
| gnt_vme | output | 1 | VME slave port owns the bus |
| dma_berr | output | 1 | Bus error returned to the DMA engine |
| vme_dtack | output | 1 | VME transfer acknowledge |
| vme_berr | output | 1 | VME bus error |

## Verification
The bench targets these corner cases, each paired with the fault it would expose:

- A request that arrives while the processor is still busy must wait. A design that yanks the grant early would drop `gnt_cpu` mid-cycle.
- `dma_req` is held high across `cyc_done`. A design without the one-cycle limit would keep `gnt_dma` up instead of passing through the idle clock.
- All three requests are raised together, and one VME qualifier is raised on its own. A wrong priority or qualification shows up as the wrong grant after the idle clock.
- The VME response is checked with parity errors under both settings of `parity_en`, and with the strobe held for several clocks. A design that pulses the response, ignores the enable, or releases early would mismatch the reference model.

// File: rtl/lb_arb_pkg.sv
// Shared types for the local bus arbiter.
// Assumes: requester index order encodes priority, higher index wins.
package lb_arb_pkg;
    localparam int N_REQ  = 3;   // number of non-processor requesters
    localparam int IX_DMA = 0;   // lowest priority
    localparam int IX_NET = 1;
    localparam int IX_VME = 2;   // highest priority

    typedef enum logic [2:0] {
        ST_CPU  = 3'd0,   // processor parked or running
        ST_GAP  = 3'd1,   // idle clock, no grant
        ST_DMA  = 3'd2,   // DMA engine tenure
        ST_NET  = 3'd3,   // network controller tenure
        ST_VRUN = 3'd4,   // VME DRAM cycle in progress
        ST_VRSP = 3'd5    // VME response held until strobe drops
    } arb_st_t;
endpackage

// File: rtl/lb_prio_pick.sv
// Fixed-priority picker: returns a one-hot vector of the highest-index
// request that is set, plus a flag that any request is set.
// Assumes: purely combinational, N >= 1.
module lb_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [N:0] seen_hi;   // seen_hi[i]: a request exists at index >= i

    assign seen_hi[N] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_pick
        // a request wins when nothing above it is requesting
        assign pick[i]    = req[i] & ~seen_hi[i+1];
        assign seen_hi[i] = req[i] |  seen_hi[i+1];
    end

    assign any = seen_hi[0];
endmodule

// File: rtl/lb_vme_resp.sv
// VME response holder: latches DTACK or BERR when the granted DRAM cycle
// completes and keeps it until the port releases the bus.
// Assumes: capture and release never coincide (different arbiter states).
module lb_vme_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic err,
    input  logic release_i,
    output logic dtack,
    output logic berr
);
    // hold the selected response from cycle end until strobe release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtack <= 1'b0;
            berr  <= 1'b0;
        end else if (capture) begin
            dtack <= ~err;
            berr  <= err;
        end else if (release_i) begin
            dtack <= 1'b0;
            berr  <= 1'b0;
        end
    end
endmodule

// File: rtl/lb_arbiter.sv
// Local bus arbiter. The processor is parked as the default owner. DMA,
// network and VME requesters are granted by fixed priority after a
// one-clock idle gap.
// Assumes: cyc_done/cyc_rd/cyc_err come from the DRAM timing logic and
// refer to the current owner's cycle; cpu_busy marks a processor cycle.
module lb_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_busy,
    input  logic dma_req,
    input  logic net_req,
    input  logic vme_sel,
    input  logic vme_strobe,
    input  logic cyc_done,
    input  logic cyc_rd,
    input  logic cyc_err,
    input  logic parity_en,
    output logic gnt_cpu,
    output logic gnt_dma,
    output logic gnt_net,
    output logic gnt_vme,
    output logic dma_berr,
    output logic vme_dtack,
    output logic vme_berr
);
    import lb_arb_pkg::*;

    arb_st_t          st_q, st_d;
    logic [N_REQ-1:0] req_vec;
    logic [N_REQ-1:0] win;
    logic             any_req;
    logic             vme_cap;
    logic             vme_rel;

    // gather requests, VME qualified by DRAM select and strobe
    always_comb begin
        req_vec         = '0;
        req_vec[IX_DMA] = dma_req;
        req_vec[IX_NET] = net_req;
        req_vec[IX_VME] = vme_sel & vme_strobe;
    end

    lb_prio_pick #(.N(N_REQ)) u_pick (
        .req  (req_vec),
        .pick (win),
        .any  (any_req)
    );

    // next owner selection, transfers only at cycle boundaries
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CPU:  if (any_req && !cpu_busy) st_d = ST_GAP;
            ST_GAP: begin
                if      (win[IX_VME]) st_d = ST_VRUN;
                else if (win[IX_NET]) st_d = ST_NET;
                else if (win[IX_DMA]) st_d = ST_DMA;
                else                  st_d = ST_CPU;
            end
            ST_DMA:  if (cyc_done)    st_d = ST_GAP;
            ST_NET:  if (!net_req)    st_d = ST_GAP;
            ST_VRUN: if (cyc_done)    st_d = ST_VRSP;
            ST_VRSP: if (!vme_strobe) st_d = ST_GAP;
            default:                  st_d = ST_GAP;
        endcase
    end

    // owner state register, processor parked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_CPU;
        else        st_q <= st_d;
    end

    assign vme_cap = (st_q == ST_VRUN) && cyc_done;
    assign vme_rel = (st_q == ST_VRSP) && !vme_strobe;

    lb_vme_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (vme_cap),
        .err       (parity_en & cyc_err),
        .release_i (vme_rel),
        .dtack     (vme_dtack),
        .berr      (vme_berr)
    );

    // grant decode from the owner state
    always_comb begin
        gnt_cpu = (st_q == ST_CPU);
        gnt_dma = (st_q == ST_DMA);
        gnt_net = (st_q == ST_NET);
        gnt_vme = (st_q == ST_VRUN) || (st_q == ST_VRSP);
    end

    // parity error on a DMA read goes straight back as bus error
    assign dma_berr = gnt_dma & cyc_done & cyc_rd & cyc_err;
endmodule

// File: rtl/lb_arbiter_chk.sv
// Property checker for lb_arbiter, attached by bind. Observes ports only.
module lb_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_busy,
    input logic dma_req,
    input logic net_req,
    input logic vme_sel,
    input logic vme_strobe,
    input logic cyc_done,
    input logic cyc_rd,
    input logic cyc_err,
    input logic parity_en,
    input logic gnt_cpu,
    input logic gnt_dma,
    input logic gnt_net,
    input logic gnt_vme,
    input logic dma_berr,
    input logic vme_dtack,
    input logic vme_berr
);
    logic [3:0] g;
    logic       vq;
    assign g  = {gnt_vme, gnt_net, gnt_dma, gnt_cpu};
    assign vq = vme_sel & vme_strobe;

    AST_GNT_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(g)); // R11
    AST_RESP_OWNER:  assert property (@(posedge clk) disable iff (!rst_n) (vme_dtack || vme_berr) |-> (gnt_vme && !(vme_dtack && vme_berr))); // R11
    AST_PARK_STAY:   assert property (@(posedge clk) disable iff (!rst_n) (gnt_cpu && !dma_req && !net_req && !vq) |=> gnt_cpu); // R2
    AST_PARK_RETURN: assert property (@(posedge clk) disable iff (!rst_n) (g == 4'd0 && !dma_req && !net_req && !vq) |=> gnt_cpu); // R2
    AST_CPU_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) (gnt_cpu && cpu_busy) |=> gnt_cpu); // R3
    AST_GAP_OWNER:   assert property (@(posedge clk) disable iff (!rst_n) (g != 4'd0 && $past(g) != 4'd0) |-> (g == $past(g))); // R4
    AST_PRIO_VME:    assert property (@(posedge clk) disable iff (!rst_n) (g == 4'd0 && vq) |=> gnt_vme); // R5
    AST_PRIO_NET:    assert property (@(posedge clk) disable iff (!rst_n) (g == 4'd0 && !vq && net_req) |=> gnt_net); // R5
    AST_DMA_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) (gnt_dma && cyc_done) |=> !gnt_dma); // R6
    AST_DMA_BERR:    assert property (@(posedge clk) disable iff (!rst_n) dma_berr |-> (gnt_dma && cyc_err && cyc_rd)); // R7
    AST_VME_QUAL:    assert property (@(posedge clk) disable iff (!rst_n) $rose(gnt_vme) |-> $past(vq)); // R8
    AST_RESP_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) ((vme_dtack || vme_berr) && vme_strobe) |=> $stable({vme_dtack, vme_berr})); // R9
    AST_BERR_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(vme_berr) |-> $past(parity_en && cyc_err && cyc_done)); // R9
    AST_NET_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (gnt_net && net_req) |=> gnt_net); // R10
endmodule

bind lb_arbiter lb_arbiter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy), .dma_req(dma_req),
    .net_req(net_req), .vme_sel(vme_sel), .vme_strobe(vme_strobe),
    .cyc_done(cyc_done), .cyc_rd(cyc_rd), .cyc_err(cyc_err),
    .parity_en(parity_en), .gnt_cpu(gnt_cpu), .gnt_dma(gnt_dma),
    .gnt_net(gnt_net), .gnt_vme(gnt_vme), .dma_berr(dma_berr),
    .vme_dtack(vme_dtack), .vme_berr(vme_berr)
);

// File: tb/lb_arbiter_test.sv
`timescale 1ns/100ps
module lb_arbiter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_busy = 0, dma_req = 0, net_req = 0, vme_sel = 0, vme_strobe = 0;
    logic cyc_done = 0, cyc_rd = 0, cyc_err = 0, parity_en = 0;
    logic gnt_cpu, gnt_dma, gnt_net, gnt_vme, dma_berr, vme_dtack, vme_berr;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string tag = "R1";

    // reference model state: -1 idle gap, 0 cpu, 1 dma, 2 net, 3 vme
    int    m_own = 0;
    int    m_resp = 0;   // 0 none, 1 dtack, 2 berr
    int    prev_own = 0;

    always #2.5 clk = ~clk;

    lb_arbiter uut (.*);

    // behavioural reference of the requirements
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_own = 0; m_resp = 0;
        end else begin
            case (m_own)
                0:  if ((dma_req || net_req || (vme_sel && vme_strobe)) && !cpu_busy) m_own = -1;
                -1: if (vme_sel && vme_strobe) m_own = 3;
                    else if (net_req) m_own = 2;
                    else if (dma_req) m_own = 1;
                    else m_own = 0;
                1:  if (cyc_done) m_own = -1;
                2:  if (!net_req) m_own = -1;
                3:  if (m_resp == 0) begin
                        if (cyc_done) m_resp = (parity_en && cyc_err) ? 2 : 1;
                    end else if (!vme_strobe) begin
                        m_resp = 0; m_own = -1;
                    end
                default: m_own = -1;
            endcase
        end
    end

    task automatic cmp(string what, logic act, logic exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // wait to the falling edge, compare every output with the model
    task automatic tick();
        int cur;
        @(negedge clk);
        vectors++;
        cmp("gnt_cpu", gnt_cpu, m_own == 0);
        cmp("gnt_dma", gnt_dma, m_own == 1);
        cmp("gnt_net", gnt_net, m_own == 2);
        cmp("gnt_vme", gnt_vme, m_own == 3);
        cmp("vme_dtack", vme_dtack, m_resp == 1);
        cmp("vme_berr", vme_berr, m_resp == 2);
        cmp("dma_berr", dma_berr, (m_own == 1) && cyc_done && cyc_rd && cyc_err);
        // R4 / R11 spec checks independent of the model
        cur = gnt_cpu + gnt_dma + gnt_net + gnt_vme;
        if (cur > 1) begin
            miscompares++;
            $display("FAIL R11 grant count actual %0d expected <=1", cur);
        end
        cur = gnt_cpu ? 0 : gnt_dma ? 1 : gnt_net ? 2 : gnt_vme ? 3 : -1;
        if (cur != -1 && prev_own != -1 && cur != prev_own) begin
            miscompares++;
            $display("FAIL R4 owner change without gap actual %0d expected %0d", cur, prev_own);
        end
        prev_own = cur;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_done(logic rd, logic err);
        cyc_done = 1; cyc_rd = rd; cyc_err = err;
        tick();
        cyc_done = 0; cyc_rd = 0; cyc_err = 0;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cycles > 150000);
        miscompares++;
        $display("FAIL watchdog expired actual %0d expected <150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1 reset state
        tag = "R1"; run(3);
        rst_n = 1;
        // R2 parking with nothing requesting
        tag = "R2"; run(8);
        // R3 request while processor busy must wait
        tag = "R3"; cpu_busy = 1; dma_req = 1; run(5);
        cpu_busy = 0; run(3);
        // R6 one cycle per DMA grant even with request held
        tag = "R6"; run(2); pulse_done(0, 0); run(3); pulse_done(0, 0);
        dma_req = 0; run(4);
        // R7 parity error on a DMA read, and on a write (no bus error)
        tag = "R7"; dma_req = 1; run(4); dma_req = 0; pulse_done(1, 1); run(3);
        dma_req = 1; run(4); dma_req = 0; cyc_done = 1; cyc_err = 1; cyc_rd = 0; tick();
        cyc_done = 0; cyc_err = 0; run(3);
        // R10 network holds its grant with its request
        tag = "R10"; net_req = 1; run(8); cyc_done = 1; run(2); cyc_done = 0;
        net_req = 0; run(4);
        // R8 half-qualified VME requests grant nothing
        tag = "R8"; vme_sel = 1; run(5); vme_sel = 0; vme_strobe = 1; run(5); vme_strobe = 0; run(2);
        // R5 all requesters at once: vme, then net, then dma
        tag = "R5"; dma_req = 1; net_req = 1; vme_sel = 1; vme_strobe = 1; run(3);
        pulse_done(0, 0); run(2); vme_strobe = 0; vme_sel = 0; run(3);
        net_req = 0; run(3); pulse_done(0, 0); dma_req = 0; run(4);
        // R9 VME response variants
        tag = "R9"; vme_sel = 1; vme_strobe = 1; run(4); pulse_done(1, 0); run(3);
        vme_strobe = 0; vme_sel = 0; run(3);
        parity_en = 1; vme_sel = 1; vme_strobe = 1; run(3); pulse_done(1, 1); run(3);
        vme_strobe = 0; vme_sel = 0; run(3);
        parity_en = 0; vme_sel = 1; vme_strobe = 1; run(3); pulse_done(1, 1); run(2);
        vme_strobe = 0; vme_sel = 0; run(3);
        // R11 mixed random traffic against the model
        tag = "R11";
        for (int i = 0; i < 4000; i++) begin
            cpu_busy   = ($urandom % 3) == 0;
            dma_req    = ($urandom % 4) == 0;
            net_req    = ($urandom % 5) == 0 ? ~net_req : net_req;
            vme_sel    = ($urandom % 4) != 0;
            vme_strobe = ($urandom % 6) == 0 ? ~vme_strobe : vme_strobe;
            cyc_done   = ($urandom % 3) == 0;
            cyc_rd     = $urandom % 2;
            cyc_err    = ($urandom % 4) == 0;
            parity_en  = $urandom % 2;
            tick();
        end
        // R1 reset again from a busy state
        tag = "R1"; rst_n = 0; run(2); rst_n = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule